// File: doc/BRIEF.md
# Decode-Stage Direct Branch Verifier

This block sits beside the decode stage of an out-of-order core and checks each decode group against what the fetch predictor decided. Every slot carries the attributes of one instruction: whether it is valid or already killed, its thread, its control class, the target computed from its encoding, the target the predictor chose, its predicted-taken bit, its count of source operands and its sequence number.

For each slot the block decides whether it goes on to rename, gives each forwarded slot a compacted output lane, and marks instructions with no source operands as issuable at once. Only direct unconditional transfers are resolved here, because their target is known from the encoding alone. When such a transfer's computed target differs from the predicted one, the block stops the scan of the group at that slot. It marks younger in-flight slots of the same thread as killed and, on the next cycle, pulses a registered redirect to fetch. The redirect carries the correct target, the offending sequence number, a queue-flush select for the thread and an upstream unblock if the thread was held. In the cycle after a redirect the thread is squashing, and its slots are dropped.

Top module: `bv_decode_verifier`

## Requirements
- R1: A slot with slot_sq_i set is never forwarded (pass_o low) and does not occupy an output lane.
- R2: For a forwarded slot, lane_o equals the number of forwarded slots with a lower index in the same cycle.
- R3: issue_o is high exactly for forwarded slots whose slot_nsrc_i is zero.
- R4: resolved_o equals the number of forwarded slots that have both slot_direct_i and slot_uncond_i set. Only such slots can cause a redirect.
- R5: A forwarded direct unconditional slot whose slot_tgt_i differs from slot_ptgt_i causes, one cycle later, a one-cycle pulse on rd_vld_o. The pulse comes with rd_mispred_o, rd_predbad_o, rd_squash_o and rd_taken_o all high, rd_seq_o equal to that slot's sequence number, rd_tid_o equal to its thread and rd_pc_o equal to its slot_tgt_i.
- R6: The mismatching slot is itself forwarded. Every higher-indexed slot is not forwarded in that cycle, so only the lowest-indexed mismatch produces a redirect.
- R7: In a mismatch cycle, kill_o is high for every valid slot of the same thread whose sequence number is greater, compared as 16-bit unsigned, than the offending one. It is low for all other slots.
- R8: rd_flush_o is one-hot on the redirecting thread during the redirect pulse and zero otherwise.
- R9: rd_unblock_o rises with the redirect only when thr_held_i of that thread was high in the mismatch cycle.
- R10: fatal_o is high when a forwarded slot has slot_ptaken_i set but slot_ctrl_i clear.
- R11: In the cycle after a mismatch, the mismatching thread is squashing: none of its slots is forwarded, checked or counted. Slots of other threads proceed normally.
- R12: After reset, the block drives no redirect, no flush, no unblock, and no thread is squashing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_vld_i | input | SLOTS | Slot holds an instruction |
| slot_sq_i | input | SLOTS | Instruction already killed |
| slot_tid_i | input | SLOTS x TID_W | Thread of each slot |
| slot_direct_i | input | SLOTS | Target is encoded in the instruction |
| slot_uncond_i | input | SLOTS | Transfer is unconditional |
| slot_ctrl_i | input | SLOTS | Instruction is a control transfer |
| slot_ptaken_i | input | SLOTS | Predictor said taken |
| slot_nsrc_i | input | SLOTS x SRC_W | Number of source operands |
| slot_seq_i | input | SLOTS x SEQ_W | Sequence number |
| slot_tgt_i | input | SLOTS x ADDR_W | Target computed at decode |
| slot_ptgt_i | input | SLOTS x ADDR_W | Predicted target |
| thr_held_i | input | THREADS | Thread is blocked or unblocking |
| pass_o | output | SLOTS | Slot forwarded to rename |
| issue_o | output | SLOTS | Forwarded slot may issue at any time |
| kill_o | output | SLOTS | Slot younger than the mispredict, same thread |
| lane_o | output | SLOTS x LANE_W | Output lane of a forwarded slot |
| resolved_o | output | CNT_W | Direct unconditional slots checked this cycle |
| fatal_o | output | 1 | Non-control instruction predicted taken |
| rd_vld_o | output | 1 | Redirect pulse |
| rd_mispred_o | output | 1 | Branch mispredict flag |
| rd_predbad_o | output | 1 | Prediction incorrect flag |
| rd_squash_o | output | 1 | Squash request flag |
| rd_taken_o | output | 1 | Correct path is taken |
| rd_tid_o | output | TID_W | Redirecting thread |
| rd_seq_o | output | SEQ_W | Sequence number of the offending instruction |
| rd_pc_o | output | ADDR_W | Correct next PC |
| rd_unblock_o | output | 1 | Unblock sent upstream |
| rd_flush_o | output | THREADS | Clear pending and skid queues of the thread |

## Verification
The hardest state to reach is the squashing cycle that directly follows a redirect. In that cycle the block must drop one thread's slots while it forwards and checks another thread's slots, and at the same time present the registered redirect of the previous cycle. The stimulus gets there with two back-to-back groups. The first holds a mismatch on one thread together with a younger same-thread slot, whose sequence number is large enough to be negative if it were read as signed. The second group mixes both threads, one of them carrying a further mismatch. That group shows the dropped thread cannot redirect again while the other thread can.

// File: rtl/bv_pkg.sv
package bv_pkg;
  typedef enum logic {
    TS_RUN    = 1'b0,
    TS_SQUASH = 1'b1
  } thr_st_e;

  function automatic int unsigned tid_w(input int unsigned threads);
    return (threads > 1) ? $clog2(threads) : 1;
  endfunction
endpackage

// File: rtl/bv_slot_scan.sv
module bv_slot_scan #(
  parameter int unsigned SLOTS   = 4,
  parameter int unsigned THREADS = 2,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SRC_W   = 3,
  localparam int unsigned TID_W  = bv_pkg::tid_w(THREADS),
  localparam int unsigned LANE_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]             vld_i,
  input  logic [SLOTS-1:0]             sq_i,
  input  logic [SLOTS-1:0][TID_W-1:0]  tid_i,
  input  logic [SLOTS-1:0]             direct_i,
  input  logic [SLOTS-1:0]             uncond_i,
  input  logic [SLOTS-1:0]             ctrl_i,
  input  logic [SLOTS-1:0]             ptaken_i,
  input  logic [SLOTS-1:0][SRC_W-1:0]  nsrc_i,
  input  logic [SLOTS-1:0][ADDR_W-1:0] tgt_i,
  input  logic [SLOTS-1:0][ADDR_W-1:0] ptgt_i,
  input  logic [THREADS-1:0]           thr_sq_i,
  output logic [SLOTS-1:0]             pass_o,
  output logic [SLOTS-1:0]             issue_o,
  output logic [SLOTS-1:0][LANE_W-1:0] lane_o,
  output logic [CNT_W-1:0]             resolved_o,
  output logic                         fatal_o,
  output logic                         hit_o,
  output logic [LANE_W-1:0]            hit_idx_o
);
  logic [SLOTS:0]            halt;
  logic [SLOTS:0][CNT_W-1:0] lane_cnt;
  logic [SLOTS:0][CNT_W-1:0] res_cnt;
  logic [SLOTS-1:0]          act, chk, mis, bad;

  assign halt[0]     = 1'b0;
  assign lane_cnt[0] = '0;
  assign res_cnt[0]  = '0;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    logic thr_sq;
    assign thr_sq        = thr_sq_i[tid_i[i]];
    assign act[i]        = vld_i[i] & ~sq_i[i] & ~halt[i] & ~thr_sq;
    assign chk[i]        = act[i] & direct_i[i] & uncond_i[i];
    assign mis[i]        = chk[i] & (tgt_i[i] != ptgt_i[i]);
    assign bad[i]        = act[i] & ptaken_i[i] & ~ctrl_i[i];
    assign halt[i+1]     = halt[i] | mis[i];
    assign lane_cnt[i+1] = lane_cnt[i] + CNT_W'(act[i]);
    assign res_cnt[i+1]  = res_cnt[i] + CNT_W'(chk[i]);
    assign pass_o[i]     = act[i];
    assign issue_o[i]    = act[i] & (nsrc_i[i] == '0);
    assign lane_o[i]     = lane_cnt[i][LANE_W-1:0];
  end

  assign resolved_o = res_cnt[SLOTS];
  assign fatal_o    = |bad;
  assign hit_o      = |mis;

  // mis is at most one-hot: halt masks every slot after the first mismatch
  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (mis[i]) hit_idx_o = LANE_W'(i);
    end
  end
endmodule

// File: rtl/bv_kill_mask.sv
module bv_kill_mask #(
  parameter int unsigned SLOTS   = 4,
  parameter int unsigned THREADS = 2,
  parameter int unsigned SEQ_W   = 16,
  localparam int unsigned TID_W  = bv_pkg::tid_w(THREADS)
) (
  input  logic [SLOTS-1:0]            vld_i,
  input  logic [SLOTS-1:0][TID_W-1:0] tid_i,
  input  logic [SLOTS-1:0][SEQ_W-1:0] seq_i,
  input  logic                        hit_i,
  input  logic [TID_W-1:0]            hit_tid_i,
  input  logic [SEQ_W-1:0]            hit_seq_i,
  output logic [SLOTS-1:0]            kill_o
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_kill
    assign kill_o[i] = hit_i & vld_i[i] & (tid_i[i] == hit_tid_i) &
                       (seq_i[i] > hit_seq_i);
  end
endmodule

// File: rtl/bv_redirect_reg.sv
module bv_redirect_reg #(
  parameter int unsigned THREADS = 2,
  parameter int unsigned SEQ_W   = 16,
  parameter int unsigned ADDR_W  = 32,
  localparam int unsigned TID_W  = bv_pkg::tid_w(THREADS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hit_i,
  input  logic [TID_W-1:0]   hit_tid_i,
  input  logic [SEQ_W-1:0]   hit_seq_i,
  input  logic [ADDR_W-1:0]  hit_pc_i,
  input  logic [THREADS-1:0] held_i,
  output logic [THREADS-1:0] thr_sq_o,
  output logic               rd_vld_o,
  output logic [TID_W-1:0]   rd_tid_o,
  output logic [SEQ_W-1:0]   rd_seq_o,
  output logic [ADDR_W-1:0]  rd_pc_o,
  output logic               rd_unblock_o,
  output logic [THREADS-1:0] rd_flush_o
);
  import bv_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_vld_o     <= 1'b0;
      rd_tid_o     <= '0;
      rd_seq_o     <= '0;
      rd_pc_o      <= '0;
      rd_unblock_o <= 1'b0;
    end else begin
      rd_vld_o     <= hit_i;
      rd_unblock_o <= hit_i & held_i[hit_tid_i];
      if (hit_i) begin
        rd_tid_o <= hit_tid_i;
        rd_seq_o <= hit_seq_i;
        rd_pc_o  <= hit_pc_i;
      end
    end
  end

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    thr_st_e st_q;
    logic    sel;
    assign sel = hit_i & (hit_tid_i == TID_W'(t));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= TS_RUN;
      else         st_q <= sel ? TS_SQUASH : TS_RUN;
    end
    assign thr_sq_o[t]   = (st_q == TS_SQUASH);
    assign rd_flush_o[t] = (st_q == TS_SQUASH);
  end
endmodule

// File: rtl/bv_decode_verifier.sv
module bv_decode_verifier #(
  parameter int unsigned SLOTS   = 4,
  parameter int unsigned THREADS = 2,
  parameter int unsigned SEQ_W   = 16,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SRC_W   = 3,
  localparam int unsigned TID_W  = bv_pkg::tid_w(THREADS),
  localparam int unsigned LANE_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [SLOTS-1:0]             slot_vld_i,
  input  logic [SLOTS-1:0]             slot_sq_i,
  input  logic [SLOTS-1:0][TID_W-1:0]  slot_tid_i,
  input  logic [SLOTS-1:0]             slot_direct_i,
  input  logic [SLOTS-1:0]             slot_uncond_i,
  input  logic [SLOTS-1:0]             slot_ctrl_i,
  input  logic [SLOTS-1:0]             slot_ptaken_i,
  input  logic [SLOTS-1:0][SRC_W-1:0]  slot_nsrc_i,
  input  logic [SLOTS-1:0][SEQ_W-1:0]  slot_seq_i,
  input  logic [SLOTS-1:0][ADDR_W-1:0] slot_tgt_i,
  input  logic [SLOTS-1:0][ADDR_W-1:0] slot_ptgt_i,
  input  logic [THREADS-1:0]           thr_held_i,
  output logic [SLOTS-1:0]             pass_o,
  output logic [SLOTS-1:0]             issue_o,
  output logic [SLOTS-1:0]             kill_o,
  output logic [SLOTS-1:0][LANE_W-1:0] lane_o,
  output logic [CNT_W-1:0]             resolved_o,
  output logic                         fatal_o,
  output logic                         rd_vld_o,
  output logic                         rd_mispred_o,
  output logic                         rd_predbad_o,
  output logic                         rd_squash_o,
  output logic                         rd_taken_o,
  output logic [TID_W-1:0]             rd_tid_o,
  output logic [SEQ_W-1:0]             rd_seq_o,
  output logic [ADDR_W-1:0]            rd_pc_o,
  output logic                         rd_unblock_o,
  output logic [THREADS-1:0]           rd_flush_o
);
  logic               hit;
  logic [LANE_W-1:0]  hit_idx;
  logic [TID_W-1:0]   hit_tid;
  logic [SEQ_W-1:0]   hit_seq;
  logic [ADDR_W-1:0]  hit_pc;
  logic [THREADS-1:0] thr_sq;

  bv_slot_scan #(
    .SLOTS(SLOTS), .THREADS(THREADS), .ADDR_W(ADDR_W), .SRC_W(SRC_W)
  ) u_scan (
    .vld_i(slot_vld_i), .sq_i(slot_sq_i), .tid_i(slot_tid_i),
    .direct_i(slot_direct_i), .uncond_i(slot_uncond_i), .ctrl_i(slot_ctrl_i),
    .ptaken_i(slot_ptaken_i), .nsrc_i(slot_nsrc_i), .tgt_i(slot_tgt_i),
    .ptgt_i(slot_ptgt_i), .thr_sq_i(thr_sq),
    .pass_o(pass_o), .issue_o(issue_o), .lane_o(lane_o),
    .resolved_o(resolved_o), .fatal_o(fatal_o),
    .hit_o(hit), .hit_idx_o(hit_idx)
  );

  assign hit_tid = slot_tid_i[hit_idx];
  assign hit_seq = slot_seq_i[hit_idx];
  assign hit_pc  = slot_tgt_i[hit_idx];

  bv_kill_mask #(
    .SLOTS(SLOTS), .THREADS(THREADS), .SEQ_W(SEQ_W)
  ) u_kill (
    .vld_i(slot_vld_i), .tid_i(slot_tid_i), .seq_i(slot_seq_i),
    .hit_i(hit), .hit_tid_i(hit_tid), .hit_seq_i(hit_seq), .kill_o(kill_o)
  );

  bv_redirect_reg #(
    .THREADS(THREADS), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)
  ) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .hit_tid_i(hit_tid),
    .hit_seq_i(hit_seq), .hit_pc_i(hit_pc), .held_i(thr_held_i),
    .thr_sq_o(thr_sq), .rd_vld_o(rd_vld_o), .rd_tid_o(rd_tid_o),
    .rd_seq_o(rd_seq_o), .rd_pc_o(rd_pc_o), .rd_unblock_o(rd_unblock_o),
    .rd_flush_o(rd_flush_o)
  );

  // direct unconditional transfers always take the encoded target
  assign rd_mispred_o = rd_vld_o;
  assign rd_predbad_o = rd_vld_o;
  assign rd_squash_o  = rd_vld_o;
  assign rd_taken_o   = rd_vld_o;
endmodule

// File: rtl/bv_checker.sv
module bv_checker #(
  parameter int unsigned SLOTS   = 4,
  parameter int unsigned THREADS = 2,
  parameter int unsigned SEQ_W   = 16,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned SRC_W   = 3,
  localparam int unsigned TID_W  = bv_pkg::tid_w(THREADS),
  localparam int unsigned LANE_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned CNT_W  = $clog2(SLOTS + 1)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [SLOTS-1:0]             slot_vld_i,
  input logic [SLOTS-1:0]             slot_sq_i,
  input logic [SLOTS-1:0][TID_W-1:0]  slot_tid_i,
  input logic [SLOTS-1:0]             pass_o,
  input logic [SLOTS-1:0]             issue_o,
  input logic [SLOTS-1:0]             kill_o,
  input logic [CNT_W-1:0]             resolved_o,
  input logic                         rd_vld_o,
  input logic [TID_W-1:0]             rd_tid_o,
  input logic                         rd_unblock_o,
  input logic [THREADS-1:0]           rd_flush_o
);
  logic [SLOTS-1:0] drop_viol;
  always_comb begin
    for (int i = 0; i < SLOTS; i++)
      drop_viol[i] = rd_vld_o & pass_o[i] & (slot_tid_i[i] == rd_tid_o);
  end

  AST_SKIP_SQUASHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pass_o & slot_sq_i) == '0); // R1
  AST_ISSUE_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_o & ~pass_o) == '0); // R3
  AST_RESOLVED_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resolved_o <= CNT_W'($countones(pass_o))); // R4
  AST_KILL_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_o & ~slot_vld_i) == '0); // R7
  AST_FLUSH_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rd_flush_o) == (rd_vld_o ? 1 : 0)); // R8
  AST_UNBLOCK_WITH_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_unblock_o |-> rd_vld_o); // R9
  AST_SQUASH_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_viol == '0); // R11
  AST_NO_REPEAT_THR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_vld_o |=> !(rd_vld_o && rd_tid_o == $past(rd_tid_o))); // R11
endmodule

bind bv_decode_verifier bv_checker #(
  .SLOTS(SLOTS), .THREADS(THREADS), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .SRC_W(SRC_W)
) u_chk (.*);

// File: tb/tb_bv_decode_verifier.sv
module tb_bv_decode_verifier;
  localparam int CLK_P = 10;
  localparam int S = 4;
  localparam int T = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic [S-1:0]       vld, sq, dir, unc, ctl, ptk;
  logic [S-1:0][0:0]  tid;
  logic [S-1:0][2:0]  nsrc;
  logic [S-1:0][15:0] seq;
  logic [S-1:0][31:0] tgt, ptgt;
  logic [T-1:0]       held;

  logic [S-1:0]       pass_o, issue_o, kill_o;
  logic [S-1:0][1:0]  lane_o;
  logic [2:0]         resolved_o;
  logic fatal_o, rd_vld_o, rd_mispred_o, rd_predbad_o, rd_squash_o, rd_taken_o;
  logic [0:0]  rd_tid_o;
  logic [15:0] rd_seq_o;
  logic [31:0] rd_pc_o;
  logic        rd_unblock_o;
  logic [T-1:0] rd_flush_o;

  bv_decode_verifier dut (
    .clk_i(clk), .rst_ni(rst_n), .slot_vld_i(vld), .slot_sq_i(sq),
    .slot_tid_i(tid), .slot_direct_i(dir), .slot_uncond_i(unc),
    .slot_ctrl_i(ctl), .slot_ptaken_i(ptk), .slot_nsrc_i(nsrc),
    .slot_seq_i(seq), .slot_tgt_i(tgt), .slot_ptgt_i(ptgt),
    .thr_held_i(held), .pass_o(pass_o), .issue_o(issue_o), .kill_o(kill_o),
    .lane_o(lane_o), .resolved_o(resolved_o), .fatal_o(fatal_o),
    .rd_vld_o(rd_vld_o), .rd_mispred_o(rd_mispred_o),
    .rd_predbad_o(rd_predbad_o), .rd_squash_o(rd_squash_o),
    .rd_taken_o(rd_taken_o), .rd_tid_o(rd_tid_o), .rd_seq_o(rd_seq_o),
    .rd_pc_o(rd_pc_o), .rd_unblock_o(rd_unblock_o), .rd_flush_o(rd_flush_o)
  );

  typedef struct {
    logic [S-1:0]      pass, issue, kill;
    logic [S-1:0][1:0] lane;
    int                res;
    logic              fatal;
    logic              rd;
    logic              rtid;
    logic [15:0]       rseq;
    logic [31:0]       rpc;
    logic              unb;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_fail = 0;
  logic [T-1:0] sq_exp = '0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // staging
  logic [S-1:0]       s_vld, s_sq, s_dir, s_unc, s_ctl, s_ptk;
  logic [S-1:0][0:0]  s_tid;
  logic [S-1:0][2:0]  s_nsrc;
  logic [S-1:0][15:0] s_seq;
  logic [S-1:0][31:0] s_tgt, s_ptgt;
  logic [T-1:0]       s_held;

  task automatic clear_slots();
    s_vld = '0; s_sq = '0; s_dir = '0; s_unc = '0; s_ctl = '0; s_ptk = '0;
    s_tid = '0; s_nsrc = '0; s_seq = '0; s_tgt = '0; s_ptgt = '0; s_held = '0;
  endtask

  task automatic set_slot(input int i, input bit t, input bit squashed, input bit d,
                          input bit u, input bit c, input bit pt, input int ns,
                          input int sn, input int tg, input int ptg);
    s_vld[i] = 1'b1; s_tid[i] = t; s_sq[i] = squashed; s_dir[i] = d; s_unc[i] = u;
    s_ctl[i] = c; s_ptk[i] = pt; s_nsrc[i] = 3'(ns); s_seq[i] = 16'(sn);
    s_tgt[i] = tg; s_ptgt[i] = ptg;
  endtask

  // driver: applies one group and pushes the expected outcome
  task automatic step();
    exp_t e;
    bit halt = 0;
    int cnt = 0;
    int hidx = 0;
    @(negedge clk);
    vld = s_vld; sq = s_sq; dir = s_dir; unc = s_unc; ctl = s_ctl; ptk = s_ptk;
    tid = s_tid; nsrc = s_nsrc; seq = s_seq; tgt = s_tgt; ptgt = s_ptgt; held = s_held;
    e.pass = '0; e.issue = '0; e.kill = '0; e.lane = '0; e.res = 0; e.fatal = 0;
    e.rd = 0; e.rtid = 0; e.rseq = '0; e.rpc = '0; e.unb = 0;
    for (int i = 0; i < S; i++) begin
      bit a;
      a = s_vld[i] && !s_sq[i] && !halt && !sq_exp[s_tid[i]];
      e.pass[i] = a;
      e.lane[i] = 2'(cnt);
      if (a) cnt++;
      e.issue[i] = a && s_nsrc[i] == 0;
      if (a && s_ptk[i] && !s_ctl[i]) e.fatal = 1;
      if (a && s_dir[i] && s_unc[i]) begin
        e.res++;
        if (s_tgt[i] != s_ptgt[i]) begin
          halt = 1; hidx = i; e.rd = 1;
        end
      end
    end
    if (e.rd) begin
      e.rtid = s_tid[hidx]; e.rseq = s_seq[hidx]; e.rpc = s_tgt[hidx];
      e.unb = s_held[s_tid[hidx]];
      for (int j = 0; j < S; j++)
        e.kill[j] = s_vld[j] && s_tid[j] == s_tid[hidx] && s_seq[j] > s_seq[hidx];
    end
    sq_exp = '0;
    if (e.rd) sq_exp[e.rtid] = 1'b1;
    exp_q.push_back(e);
  endtask

  // monitor: combinational results of this group, registered redirect of the previous one
  initial begin
    exp_t prev;
    prev.rd = 0; prev.rtid = 0; prev.rseq = '0; prev.rpc = '0; prev.unb = 0;
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(pass_o == e.pass, "R1/R6/R11 pass", pass_o, e.pass);
        for (int i = 0; i < S; i++)
          if (e.pass[i]) chk(lane_o[i] == e.lane[i], "R2 lane", lane_o[i], e.lane[i]);
        chk(issue_o == e.issue, "R3 issue", issue_o, e.issue);
        chk(int'(resolved_o) == e.res, "R4 resolved", resolved_o, e.res);
        chk(kill_o == e.kill, "R7 kill", kill_o, e.kill);
        chk(fatal_o == e.fatal, "R10 fatal", fatal_o, e.fatal);
        chk(rd_vld_o == prev.rd, "R5 rd_vld", rd_vld_o, prev.rd);
        chk({rd_mispred_o, rd_predbad_o, rd_squash_o, rd_taken_o} == {4{prev.rd}},
            "R5 flags", {rd_mispred_o, rd_predbad_o, rd_squash_o, rd_taken_o}, {4{prev.rd}});
        chk(rd_flush_o == (prev.rd ? (T'(1) << prev.rtid) : '0), "R8 flush",
            rd_flush_o, prev.rd ? (T'(1) << prev.rtid) : 0);
        chk(rd_unblock_o == (prev.rd && prev.unb), "R9 unblock", rd_unblock_o, prev.unb);
        if (prev.rd) begin
          chk(rd_tid_o == prev.rtid, "R5 tid", rd_tid_o, prev.rtid);
          chk(rd_seq_o == prev.rseq, "R5 seq", rd_seq_o, prev.rseq);
          chk(rd_pc_o == prev.rpc, "R5 pc", rd_pc_o, prev.rpc);
        end
        prev = e;
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    clear_slots();
    vld = '0; sq = '0; dir = '0; unc = '0; ctl = '0; ptk = '0; tid = '0;
    nsrc = '0; seq = '0; tgt = '0; ptgt = '0; held = '0;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk(rd_vld_o == 0 && rd_flush_o == 0 && rd_unblock_o == 0, "R12 reset", rd_vld_o, 0);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk(pass_o == '0 && rd_vld_o == 0, "R12 idle after reset", pass_o, 0);

    // plain group with mixed source counts: R2 R3
    clear_slots();
    for (int i = 0; i < S; i++) set_slot(i, i[0], 0, 0, 0, 0, 0, i, 10 + i, 0, 0);
    step();
    // squashed slot 1 and 2 skipped: R1
    clear_slots();
    set_slot(0, 0, 0, 0, 0, 0, 0, 2, 20, 0, 0);
    set_slot(1, 0, 1, 0, 0, 0, 0, 0, 21, 0, 0);
    set_slot(2, 1, 1, 1, 1, 1, 1, 0, 22, 'h40, 'h80);
    set_slot(3, 1, 0, 0, 0, 0, 0, 0, 23, 0, 0);
    step();
    // correct direct branch and conditional mismatch (not checked): R4
    clear_slots();
    set_slot(0, 0, 0, 1, 1, 1, 1, 1, 30, 'h100, 'h100);
    set_slot(1, 0, 0, 1, 0, 1, 1, 1, 31, 'h200, 'h300);
    set_slot(2, 1, 0, 1, 1, 1, 1, 0, 32, 'h400, 'h400);
    step();
    // mismatch at slot 1, thread 0 held; younger seq 0xfff0 killed: R5 R6 R7 R9
    clear_slots();
    s_held = 2'b01;
    set_slot(0, 0, 0, 0, 0, 0, 0, 1, 'h000f, 0, 0);
    set_slot(1, 0, 0, 1, 1, 1, 1, 2, 'h0010, 'h1234, 'h5678);
    set_slot(2, 0, 0, 0, 0, 0, 0, 0, 'hfff0, 0, 0);
    set_slot(3, 1, 0, 0, 0, 0, 0, 0, 'h0020, 0, 0);
    step();
    // thread 0 squashing; thread 1 mismatch at slot 2 not held: R11 R8
    clear_slots();
    set_slot(0, 0, 0, 1, 1, 1, 1, 0, 'h0030, 'h10, 'h20);
    set_slot(1, 1, 0, 0, 0, 0, 0, 0, 'h0031, 0, 0);
    set_slot(2, 1, 0, 1, 1, 1, 1, 1, 'h0032, 'habc0, 'h0);
    set_slot(3, 1, 0, 0, 0, 0, 0, 0, 'h0033, 0, 0);
    step();
    // two mismatches: only lowest wins: R6
    clear_slots();
    s_held = 2'b11;
    set_slot(0, 0, 0, 0, 0, 0, 0, 1, 'h0040, 0, 0);
    set_slot(1, 0, 0, 1, 1, 1, 1, 0, 'h0041, 'h7000, 'h7004);
    set_slot(2, 0, 0, 1, 1, 1, 1, 0, 'h0042, 'h8000, 'h8004);
    step();
    // fatal: non-control predicted taken; thread 0 squashing drops slot 0: R10 R11
    clear_slots();
    set_slot(0, 0, 0, 0, 0, 0, 1, 1, 'h0050, 0, 0);
    set_slot(1, 1, 0, 0, 0, 0, 1, 1, 'h0051, 0, 0);
    step();
    clear_slots();
    set_slot(0, 0, 0, 0, 0, 0, 1, 0, 'h0060, 0, 0);
    step();
    clear_slots();
    repeat (3) step();
    repeat (3) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule